// File: doc/BRIEF.md
# Fixed-Service Memory Slot Scheduler

This block shares one memory channel among several security domains without letting any domain learn how busy the others are. Time on the channel is cut into slots of a fixed number of cycles. The slots are handed to the domains in a fixed round-robin order, and one turn of the rotation is called a quantum. Each slot moves exactly one read or one write burst. The row-activate and column commands for that burst are issued at cycle offsets set only by the slot boundary. The traffic of the domains has no effect on those offsets.

Each domain offers the head of its own request queue through a valid/ready pair. At the first cycle of a slot the scheduler looks only at the domain that owns the slot. If that domain has a request, the scheduler accepts it. If the queue is empty, the scheduler makes up a dummy read to the same domain's rank, with the same timing. As a result the command/address bus carries the same pattern of command times whatever the load. The slot length is a parameter. It must cover one burst plus the rank turnaround gap, and it must keep read and write command offsets from colliding on the shared command bus.

Top module: `fss_sched`

## Requirements
- R1: The slot counter counts SLOT_LEN cycles per slot. Slot k is owned by domain k mod N_DOM, and its decision cycle is the first cycle of the slot. Slot 0 starts on the first cycle after reset is released.
- R2: `req_ready[d]` is high only in the decision cycle of a slot owned by domain d, and only while `req_valid[d]` is high. At most one bit of `req_ready` is set at a time.
- R3: For an accepted read, the activate (`cmd_cas`=0) appears on the bus one cycle after the decision clock edge. The column command (`cmd_cas`=1, `cmd_write`=0) follows T_RCD cycles later.
- R4: For an accepted write, the activate is delayed by a further T_CAS−T_CWD cycles compared with a read. The column command (`cmd_write`=1) follows T_RCD cycles after the activate. Read data and write data therefore both start T_RCD+T_CAS cycles after the decision edge.
- R5: Every command of a slot carries the owning domain's index on `cmd_rank`. A real request carries its own `req_bank` value on `cmd_bank`.
- R6: When the owning domain has no valid request at the decision cycle, no grant is given. A dummy read is issued with read timing, `cmd_dummy`=1, `cmd_write`=0, `cmd_rank` equal to the domain index and `cmd_bank`=DUMMY_BANK.
- R7: A request that becomes valid after its domain's decision cycle is not taken in that slot. It is served in the domain's next slot, N_DOM slots later. Requests of one domain are served in arrival order.
- R8: The cycles at which a domain's commands appear do not depend on the traffic of the other domains.
- R9: At most one command is on the command bus in any cycle. In cycles that carry no scheduled command, `cmd_valid` is 0.
- R10: While reset is held, `cmd_valid` and all bits of `req_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N_DOM | Head-of-queue valid, one bit per domain |
| req_write | input | N_DOM | Head request is a write (1) or a read (0) |
| req_bank | input | N_DOM*BANK_W | Head request bank, domain d in bits [d*BANK_W +: BANK_W] |
| req_ready | output | N_DOM | Slot grant: head request of that domain is taken at this edge |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_cas | output | 1 | 0 = row activate, 1 = column command |
| cmd_write | output | 1 | Command belongs to a write burst |
| cmd_rank | output | RANK_W | Rank field (owning domain index) |
| cmd_bank | output | BANK_W | Bank field |
| cmd_dummy | output | 1 | Command belongs to a dummy access |

## Verification
The grant is combinational. It is sampled in the same cycle as the decision, after the inputs settle. The read activate is due on the sample one cycle after the decision edge. The write activate comes T_CAS−T_CWD samples later than that, and each column command comes T_RCD samples after its activate. The bench keeps a reference timeline, indexed by sample number, that it fills at each decision cycle from its own queue model. At every sample it compares the bus to that timeline, so early, late or missing commands all miscompare. Two passes with identical domain-0 stimulus, one with the other domains busy and one with them idle, must give the same domain-0 command stamps.

// File: rtl/fss_pkg.sv
package fss_pkg;

   typedef enum logic {
      FSS_ACT = 1'b0,
      FSS_CAS = 1'b1
   } fss_cmd_e;

   // True when two command offsets of different slots could fall in one cycle
   function automatic bit fss_offsets_clash(input int slot_len, input int rcd, input int shift);
      bit clash;
      clash = (rcd % slot_len) == 0;
      if (shift != 0) begin
         if ((shift % slot_len) == 0) clash = 1'b1;
         if (((rcd + shift) % slot_len) == 0) clash = 1'b1;
         if ((((rcd > shift) ? rcd - shift : shift - rcd) % slot_len) == 0) clash = 1'b1;
      end
      return clash;
   endfunction

endpackage

// File: rtl/fss_slot_timer.sv
module fss_slot_timer #(
   parameter int N_DOM    = 4,
   parameter int SLOT_LEN = 7,
   localparam int CNT_W   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1,
   localparam int DOM_W   = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic             decide,
   output logic [DOM_W-1:0] dom
);

   logic [CNT_W-1:0] cnt;
   logic             slot_end;

   assign slot_end = (cnt == CNT_W'(SLOT_LEN - 1));
   assign decide   = !rst && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         dom <= '0;
      end else if (slot_end) begin
         cnt <= '0;
         dom <= (dom == DOM_W'(N_DOM - 1)) ? '0 : dom + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R1
   owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !slot_end |=> $stable(dom));

   // R1
   decide_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      decide |=> !decide);

endmodule

// File: rtl/fss_slot_pick.sv
module fss_slot_pick #(
   parameter int         N_DOM      = 4,
   parameter int         BANK_W     = 3,
   parameter logic [BANK_W-1:0] DUMMY_BANK = '0,
   localparam int        DOM_W      = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
   input  logic                    decide,
   input  logic [DOM_W-1:0]        dom,
   input  logic [N_DOM-1:0]        req_valid,
   input  logic [N_DOM-1:0]        req_write,
   input  logic [N_DOM*BANK_W-1:0] req_bank,
   output logic [N_DOM-1:0]        req_ready,
   output logic                    sel_wr,
   output logic                    sel_dummy,
   output logic [BANK_W-1:0]       sel_bank
);

   logic [N_DOM-1:0]  own;
   logic              own_valid;
   logic              own_write;
   logic [BANK_W-1:0] own_bank;

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      assign own[d]       = (dom == DOM_W'(d));
      assign req_ready[d] = decide && own[d] && req_valid[d];
   end

   always_comb begin
      own_valid = 1'b0;
      own_write = 1'b0;
      own_bank  = '0;
      for (int d = 0; d < N_DOM; d++) begin
         if (own[d]) begin
            own_valid = req_valid[d];
            own_write = req_write[d];
            own_bank  = req_bank[d*BANK_W +: BANK_W];
         end
      end
   end

   // An empty owner turns into a read to its own rank at the fixed dummy bank
   assign sel_dummy = !own_valid;
   assign sel_wr    = own_valid && own_write;
   assign sel_bank  = own_valid ? own_bank : DUMMY_BANK;

endmodule

// File: rtl/fss_cmd_pipe.sv
module fss_cmd_pipe #(
   parameter int  N_DOM    = 4,
   parameter int  BANK_W   = 3,
   parameter int  SLOT_LEN = 7,
   parameter int  T_RCD    = 11,
   parameter int  WR_SHIFT = 6,
   localparam int RANK_W   = (N_DOM > 1) ? $clog2(N_DOM) : 1,
   localparam int MAX_OFF  = T_RCD + WR_SHIFT,
   localparam int DEPTH    = MAX_OFF / SLOT_LEN + 1,
   localparam int AGE_W    = $clog2(MAX_OFF + 1),
   localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              ld_wr,
   input  logic              ld_dummy,
   input  logic [RANK_W-1:0] ld_rank,
   input  logic [BANK_W-1:0] ld_bank,
   output logic              cmd_valid,
   output logic              cmd_cas,
   output logic              cmd_write,
   output logic [RANK_W-1:0] cmd_rank,
   output logic [BANK_W-1:0] cmd_bank,
   output logic              cmd_dummy
);
   import fss_pkg::*;

   logic [DEPTH-1:0]  e_v, e_wr, e_dm, emit_act, emit_cas;
   logic [RANK_W-1:0] e_rank [DEPTH];
   logic [BANK_W-1:0] e_bank [DEPTH];
   logic [AGE_W-1:0]  e_age  [DEPTH];
   logic [PTR_W-1:0]  wp;

   if (DEPTH > 1) begin : g_ring
      always_ff @(posedge clk) begin
         if (rst)       wp <= '0;
         else if (load) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
   end else begin : g_single
      assign wp = '0;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [AGE_W-1:0] act_off, cas_off;
      assign act_off     = e_wr[i] ? AGE_W'(WR_SHIFT) : '0;
      assign cas_off     = act_off + AGE_W'(T_RCD);
      assign emit_act[i] = e_v[i] && (e_age[i] == act_off);
      assign emit_cas[i] = e_v[i] && (e_age[i] == cas_off);

      always_ff @(posedge clk) begin
         if (rst) begin
            e_v[i]    <= 1'b0;
            e_wr[i]   <= 1'b0;
            e_dm[i]   <= 1'b0;
            e_rank[i] <= '0;
            e_bank[i] <= '0;
            e_age[i]  <= '0;
         end else if (load && (wp == PTR_W'(i))) begin
            e_v[i]    <= 1'b1;
            e_wr[i]   <= ld_wr;
            e_dm[i]   <= ld_dummy;
            e_rank[i] <= ld_rank;
            e_bank[i] <= ld_bank;
            e_age[i]  <= '0;
         end else if (e_v[i]) begin
            if (e_age[i] == cas_off) e_v[i] <= 1'b0;
            else                     e_age[i] <= e_age[i] + 1'b1;
         end
      end
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_cas   = FSS_ACT;
      cmd_write = 1'b0;
      cmd_rank  = '0;
      cmd_bank  = '0;
      cmd_dummy = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (emit_act[i] || emit_cas[i]) begin
            cmd_valid = 1'b1;
            cmd_cas   = emit_cas[i] ? FSS_CAS : FSS_ACT;
            cmd_write = e_wr[i];
            cmd_rank  = e_rank[i];
            cmd_bank  = e_bank[i];
            cmd_dummy = e_dm[i];
         end
      end
   end

   // R9
   single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({emit_act, emit_cas}) <= 1);

   // R9
   no_live_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
      load |-> !e_v[wp]);

endmodule

// File: rtl/fss_sched.sv
module fss_sched #(
   parameter int  N_DOM      = 4,
   parameter int  SLOT_LEN   = 7,
   parameter int  T_CAS      = 11,
   parameter int  T_CWD      = 5,
   parameter int  T_RCD      = 11,
   parameter int  T_BURST    = 4,
   parameter int  T_RTRS     = 2,
   parameter int  BANK_W     = 3,
   parameter int  DUMMY_BANK = 0,
   localparam int RANK_W     = (N_DOM > 1) ? $clog2(N_DOM) : 1,
   localparam int DOM_W      = RANK_W,
   localparam int WR_SHIFT   = T_CAS - T_CWD
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [N_DOM-1:0]        req_valid,
   input  logic [N_DOM-1:0]        req_write,
   input  logic [N_DOM*BANK_W-1:0] req_bank,
   output logic [N_DOM-1:0]        req_ready,
   output logic                    cmd_valid,
   output logic                    cmd_cas,
   output logic                    cmd_write,
   output logic [RANK_W-1:0]       cmd_rank,
   output logic [BANK_W-1:0]       cmd_bank,
   output logic                    cmd_dummy
);
   import fss_pkg::*;

   if (SLOT_LEN < T_BURST + T_RTRS) begin : g_bad_len
      $error("slot shorter than burst plus rank turnaround");
   end
   if (T_CWD > T_CAS) begin : g_bad_cwd
      $error("write latency must not exceed read latency");
   end
   if (fss_offsets_clash(SLOT_LEN, T_RCD, WR_SHIFT)) begin : g_bad_clash
      $error("slot length lets command offsets collide on the bus");
   end
   if (N_DOM < 1 || BANK_W < 1) begin : g_bad_size
      $error("need at least one domain and one bank bit");
   end

   logic              decide;
   logic [DOM_W-1:0]  dom;
   logic              sel_wr, sel_dummy;
   logic [BANK_W-1:0] sel_bank;

   fss_slot_timer #(.N_DOM(N_DOM), .SLOT_LEN(SLOT_LEN)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .decide (decide),
      .dom    (dom)
   );

   fss_slot_pick #(.N_DOM(N_DOM), .BANK_W(BANK_W),
                   .DUMMY_BANK(BANK_W'(DUMMY_BANK))) u_pick (
      .decide    (decide),
      .dom       (dom),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_bank  (req_bank),
      .req_ready (req_ready),
      .sel_wr    (sel_wr),
      .sel_dummy (sel_dummy),
      .sel_bank  (sel_bank)
   );

   fss_cmd_pipe #(.N_DOM(N_DOM), .BANK_W(BANK_W), .SLOT_LEN(SLOT_LEN),
                  .T_RCD(T_RCD), .WR_SHIFT(WR_SHIFT)) u_pipe (
      .clk       (clk),
      .rst       (rst),
      .load      (decide),
      .ld_wr     (sel_wr),
      .ld_dummy  (sel_dummy),
      .ld_rank   (dom),
      .ld_bank   (sel_bank),
      .cmd_valid (cmd_valid),
      .cmd_cas   (cmd_cas),
      .cmd_write (cmd_write),
      .cmd_rank  (cmd_rank),
      .cmd_bank  (cmd_bank),
      .cmd_dummy (cmd_dummy)
   );

   // R2
   one_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_ready));

   // R2
   grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (req_ready & ~req_valid) == '0);

   // R6
   dummy_is_read_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_dummy) |-> !cmd_write);

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> (!cmd_valid && req_ready == '0));

endmodule

// File: tb/sim_fss_sched.sv
module sim_fss_sched;
   localparam int N    = 4;
   localparam int L    = 7;
   localparam int RCD  = 11;
   localparam int SH   = 6;
   localparam int BW   = 3;
   localparam int SPAN = 154;
   localparam int EMAX = SPAN + RCD + SH + 4;

   // stimulus table: sample of arrival, domain, write flag, bank
   localparam int NV = 12;
   localparam int VS[NV] = '{0, 1, 8, 10, 15, 20, 21, 22, 29, 40, 60, 70};
   localparam int VD[NV] = '{0, 1, 1,  2,  2,  3,  3,  0,  0,  1,  2,  3};
   localparam int VW[NV] = '{0, 1, 0,  1,  0,  1,  0,  1,  0,  1,  0,  1};
   localparam int VB[NV] = '{5, 2, 3,  7,  1,  4,  6,  3,  0,  1,  2,  5};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst;
   logic [N-1:0]    req_valid, req_write, req_ready;
   logic [N*BW-1:0] req_bank;
   logic            cmd_valid, cmd_cas, cmd_write, cmd_dummy;
   logic [1:0]      cmd_rank;
   logic [BW-1:0]   cmd_bank;

   fss_sched u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_bank(req_bank), .req_ready(req_ready), .cmd_valid(cmd_valid),
      .cmd_cas(cmd_cas), .cmd_write(cmd_write), .cmd_rank(cmd_rank),
      .cmd_bank(cmd_bank), .cmd_dummy(cmd_dummy)
   );

   int vecs = 0;
   int miss = 0;
   bit done = 1'b0;

   bit ev [EMAX];
   bit ec [EMAX];
   bit ew [EMAX];
   bit ed [EMAX];
   int er [EMAX];
   int eb [EMAX];

   int qw [N][16];
   int qb [N][16];
   int qh [N];
   int qt [N];

   int st [2][64];
   int sn [2];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         miss++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive();
      for (int d = 0; d < N; d++) begin
         req_valid[d] = (qh[d] != qt[d]);
         req_write[d] = (qh[d] != qt[d]) ? qw[d][qh[d]][0] : 1'b0;
         req_bank[d*BW +: BW] = (qh[d] != qt[d]) ? BW'(qb[d][qh[d]]) : '0;
      end
   endtask

   task automatic run_phase(input int ph);
      for (int t = 0; t < EMAX; t++) begin
         ev[t] = 0; ec[t] = 0; ew[t] = 0; ed[t] = 0; er[t] = 0; eb[t] = 0;
      end
      for (int d = 0; d < N; d++) begin
         qh[d] = 0; qt[d] = 0;
      end
      sn[ph] = 0;
      rst = 1'b1;
      req_valid = '0; req_write = '0; req_bank = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R10: quiet bus and no grant while reset is held
      chk(!cmd_valid && req_ready == '0, "R10", {cmd_valid, req_ready}, 0);
      rst = 1'b0;
      for (int s = 0; s < SPAN; s++) begin
         if (s > 0) @(negedge clk);
         for (int v = 0; v < NV; v++) begin
            if (VS[v] == s && (ph == 0 || VD[v] == 0)) begin
               qw[VD[v]][qt[VD[v]]] = VW[v];
               qb[VD[v]][qt[VD[v]]] = VB[v];
               qt[VD[v]]++;
            end
         end
         drive();
         #1;
         // command bus against the reference timeline (R3, R4, R6, R9)
         if (!ev[s]) begin
            chk(!cmd_valid, "R9", cmd_valid, 0);
         end else begin
            chk(cmd_valid && cmd_cas == ec[s] && cmd_write == ew[s] && cmd_dummy == ed[s],
                ed[s] ? "R6" : (ew[s] ? "R4" : "R3"),
                {cmd_valid, cmd_cas, cmd_write, cmd_dummy},
                {1'b1, ec[s], ew[s], ed[s]});
            chk(int'(cmd_rank) == er[s] && int'(cmd_bank) == eb[s], "R5",
                int'(cmd_rank) * 8 + int'(cmd_bank), er[s] * 8 + eb[s]);
         end
         if (cmd_valid && cmd_rank == 2'd0 && sn[ph] < 64) begin
            st[ph][sn[ph]] = s * 8 + int'(cmd_cas) * 4 + int'(cmd_write) * 2 + int'(cmd_dummy);
            sn[ph]++;
         end
         // R7: read that arrived late at s=8 is served in slot 5, activate at s=36
         if (ph == 0 && s == 36) begin
            chk(cmd_valid && !cmd_cas && cmd_rank == 2'd1 && cmd_bank == 3'd3 && !cmd_dummy,
                "R7", int'(cmd_bank), 3);
         end
         if (s % L == 0) begin
            int  d;
            bit  real_req;
            int  wr;
            int  bk;
            int  ta;
            d = (s / L) % N;
            real_req = (qh[d] != qt[d]);
            wr = real_req ? qw[d][qh[d]] : 0;
            bk = real_req ? qb[d][qh[d]] : 0;
            // R1, R2: only the owner is granted, and only with a request
            chk(req_ready == (real_req ? N'(1 << d) : N'(0)), real_req ? "R2" : "R1",
                int'(req_ready), real_req ? (1 << d) : 0);
            ta = s + 1 + (wr != 0 ? SH : 0);
            ev[ta] = 1; ec[ta] = 0; ew[ta] = (wr != 0); ed[ta] = !real_req; er[ta] = d; eb[ta] = bk;
            ev[ta + RCD] = 1; ec[ta + RCD] = 1; ew[ta + RCD] = (wr != 0);
            ed[ta + RCD] = !real_req; er[ta + RCD] = d; eb[ta + RCD] = bk;
            if (real_req) qh[d]++;
         end
      end
   endtask

   initial begin
      run_phase(0);
      run_phase(1);
      // R8: domain 0 stamps are identical with busy and idle neighbours
      chk(sn[0] == sn[1], "R8", sn[1], sn[0]);
      for (int i = 0; i < 64; i++) begin
         if (i < sn[0] && i < sn[1]) chk(st[0][i] == st[1][i], "R8", st[1][i], st[0][i]);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         vecs++;
         miss++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end

endmodule